// File: doc/BRIEF.md
# 8-bit Timer with Compare PWM

This block is an 8-bit timer/counter with two output-compare channels. A prescaler divides the system clock by a selectable power of two, or holds the counter stopped. The counter runs in one of three waveform modes. In free-running mode it counts up and wraps. In reload mode it returns to zero when it matches compare channel A. In phase-correct PWM mode it counts up to the maximum and back down to zero. Each channel drives one waveform pin. Three event flags (overflow, match A, match B) feed one interrupt request through a mask.

Software reaches the block through a plain single-cycle register port. Writes take effect on the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`. The port has no back-pressure: every write is accepted, and read data is valid in the same cycle. The register map is: 0 control (bits [1:0] mode: 0 free-running, 1 reload, 2 PWM, 3 acts as free-running; bits [4:2] clock select), 1 counter, 2 compare A, 3 compare B, 4 flags, 5 mask. The flag and mask bit positions are bit 0 overflow, bit 1 match A and bit 2 match B. Unmapped addresses read as zero.

Top module: `tmr8_pwm`

## Requirements
- R1: After reset, every register reads 0, and `wave_a`, `wave_b` and `irq` are low.
- R2: Clock-select codes 1..7 advance the counter once every 1, 8, 32, 64, 128, 256 and 1024 clocks. After a start from a stopped state, the counter equals floor(N/D) N edges later. Code 0 freezes the counter and clears the prescaler.
- R3: In free-running mode the counter increments on each timer tick. It wraps from 255 to 0, and the overflow flag (bit 0) is set on that wrapping edge.
- R4: In reload mode the counter goes to 0 on the tick after it equals the active compare A value. Starting from 0, after N ticks it holds N mod (A+1).
- R5: In PWM mode the counter climbs from 0 to 255 and then falls to 0, repeating with a period of 510 ticks. The overflow flag is set when the counter steps up off 0 after a descent.
- R6: On a tick where the counter equals a channel's active compare value, that channel's flag is set (A is bit 1, B is bit 2). A tick on the same edge as a counter write produces no flag event.
- R7: Compare registers read back the last written value. In PWM mode a written value becomes active only on the tick that leaves 255. In the other modes it becomes active on the write edge.
- R8: In PWM mode a match on an upward step drives the channel output low, and a match on a downward step drives it high.
- R9: In free-running and reload modes a channel output toggles on each of its matches, and it is otherwise steady.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A hardware set on the same edge wins.
- R11: `irq` is high exactly when some flag is set whose mask bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| irq | output | 1 | Combined masked interrupt request |

## Verification
The assertions assume that at most one register write occurs per clock. They also assume that a counter write cancels any tick event on that edge, so every property about a step excludes edges carrying a counter write. The stimulus issues writes one cycle apart, changes mode only while the prescaler is stopped or from reset, and sweeps the prescaler ratios, a spread of reload values including 0 and 255, and PWM periods with compare updates made during a descent. This keeps the checked windows free of unmodelled overlaps.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_CTC  = 2'd1,
    MODE_PWM  = 2'd2,
    MODE_ALT  = 2'd3
  } mode_e;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_CNT  = 3'd1;
  localparam logic [2:0] ADDR_CMPA = 3'd2;
  localparam logic [2:0] ADDR_CMPB = 3'd3;
  localparam logic [2:0] ADDR_FLAG = 3'd4;
  localparam logic [2:0] ADDR_MASK = 3'd5;

  // log2 of the divide ratio for each clock-select code
  function automatic int unsigned clk_shift(input logic [2:0] sel);
    case (sel)
      3'd2:    return 3;
      3'd3:    return 5;
      3'd4:    return 6;
      3'd5:    return 7;
      3'd6:    return 8;
      3'd7:    return 10;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] msk;

  always_comb msk = (PRE_W'(1) << clk_shift(sel)) - PRE_W'(1);

  assign tick = (sel != 3'd0) && ((pre_q & msk) == msk);

  always_ff @(posedge clk) begin
    if (!rst_n)             pre_q <= '0;
    else if (sel == 3'd0)   pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  mode_e        mode,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] cmp_a,
  output logic [W-1:0] cnt_q,
  output logic         step_up,
  output logic         evt,
  output logic         top_evt,
  output logic         ovf_evt
);
  localparam logic [W-1:0] MAXV = '1;
  logic dir_up_q;
  logic pwm, ctc;

  assign pwm = (mode == MODE_PWM);
  assign ctc = (mode == MODE_CTC);

  // direction of the step about to be taken
  always_comb begin
    if (pwm) step_up = (dir_up_q && cnt_q != MAXV) || (!dir_up_q && cnt_q == '0);
    else     step_up = 1'b1;
  end

  assign evt     = tick && !ld;
  assign top_evt = evt && pwm && (cnt_q == MAXV);
  assign ovf_evt = evt && (pwm ? (cnt_q == '0 && !dir_up_q) : (cnt_q == MAXV));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      dir_up_q <= 1'b1;
    end else begin
      if (!pwm) dir_up_q <= 1'b1;
      if (ld) begin
        cnt_q <= ld_val;
      end else if (tick) begin
        if (pwm) begin
          cnt_q    <= step_up ? cnt_q + 1'b1 : cnt_q - 1'b1;
          dir_up_q <= step_up;
        end else if (ctc && cnt_q == cmp_a) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tmr8_compare.sv
module tmr8_compare #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         pwm,
  input  logic         top_evt,
  input  logic         evt,
  input  logic [W-1:0] cnt,
  input  logic         step_up,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q,
  output logic         match,
  output logic         wave_q
);
  assign match = evt && (cnt == act_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= '0;
      act_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      if (wr) buf_q <= wdata;
      if (!pwm)         act_q <= wr ? wdata : buf_q;
      else if (top_evt) act_q <= buf_q;
      if (match) wave_q <= pwm ? !step_up : !wave_q;
    end
  end
endmodule

// File: rtl/tmr8_pwm.sv
module tmr8_pwm
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             wave_a,
  output logic             wave_b,
  output logic             irq
);
  localparam int NFLAG = NCH + 1;

  mode_e            mode_q;
  logic [2:0]       cs_q;
  logic [NFLAG-1:0] flag_q, mask_q, flag_set, flag_clr;
  logic             tick, step_up, evt, top_evt, ovf_evt, cnt_wr;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_v [NCH];
  logic [CNT_W-1:0] buf_v [NCH];
  logic [NCH-1:0]   match_v, wave_v;

  assign cnt_wr = reg_we && (reg_addr == ADDR_CNT);

  tmr8_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .sel(cs_q), .tick(tick)
  );

  tmr8_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode_q),
    .ld(cnt_wr), .ld_val(reg_wdata), .cmp_a(act_v[0]),
    .cnt_q(cnt_q), .step_up(step_up), .evt(evt),
    .top_evt(top_evt), .ovf_evt(ovf_evt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr8_compare #(.W(CNT_W)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .wr(reg_we && reg_addr == 3'(ADDR_CMPA + i)),
      .wdata(reg_wdata), .pwm(mode_q == MODE_PWM),
      .top_evt(top_evt), .evt(evt), .cnt(cnt_q), .step_up(step_up),
      .buf_q(buf_v[i]), .act_q(act_v[i]),
      .match(match_v[i]), .wave_q(wave_v[i])
    );
  end

  assign flag_set = {match_v, ovf_evt};
  assign flag_clr = (reg_we && reg_addr == ADDR_FLAG) ? reg_wdata[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_FREE;
      cs_q   <= '0;
      flag_q <= '0;
      mask_q <= '0;
    end else begin
      if (reg_we && reg_addr == ADDR_CTRL) begin
        mode_q <= mode_e'(reg_wdata[1:0]);
        cs_q   <= reg_wdata[4:2];
      end
      if (reg_we && reg_addr == ADDR_MASK) mask_q <= reg_wdata[NFLAG-1:0];
      flag_q <= (flag_q & ~flag_clr) | flag_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: reg_rdata = CNT_W'({cs_q, mode_q});
      ADDR_CNT:  reg_rdata = cnt_q;
      ADDR_CMPA: reg_rdata = buf_v[0];
      ADDR_CMPB: reg_rdata = buf_v[1];
      ADDR_FLAG: reg_rdata = CNT_W'(flag_q);
      ADDR_MASK: reg_rdata = CNT_W'(mask_q);
      default:   reg_rdata = '0;
    endcase
  end

  assign wave_a = wave_v[0];
  assign wave_b = wave_v[1];
  assign irq    = |(flag_q & mask_q);
endmodule

// File: rtl/tmr8_pwm_chk.sv
module tmr8_pwm_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [2:0]   reg_addr,
  input logic         tick,
  input logic [1:0]   mode,
  input logic [W-1:0] cnt,
  input logic [W-1:0] act_a,
  input logic [2:0]   flags,
  input logic [2:0]   mask,
  input logic         wave_a,
  input logic         irq
);
  logic cnt_wr, step;
  assign cnt_wr = reg_we && (reg_addr == 3'd1);
  assign step   = tick && !cnt_wr;

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !step && !cnt_wr |=> $stable(cnt)); // R2
  AST_CTC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode == 2'd1 && cnt == act_a |=> cnt == '0); // R4
  AST_PWM_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    step && mode == 2'd2 && cnt == '1 |=> cnt == {{(W-1){1'b1}}, 1'b0}); // R5
  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    step && cnt == act_a |=> flags[1]); // R6
  AST_PWM_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 && !(step && cnt == '1) |=> $stable(act_a)); // R7
  AST_WAVE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(wave_a)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    mask == 3'b000 |-> !irq); // R11
endmodule

bind tmr8_pwm tmr8_pwm_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .tick(tick), .mode(mode_q), .cnt(cnt_q), .act_a(act_v[0]),
  .flags(flag_q), .mask(mask_q), .wave_a(wave_v[0]), .irq(irq)
);

// File: tb/tmr8_pwm_bench.sv
module tmr8_pwm_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       wave_a, wave_b, irq;
  int checks = 0;
  int failures = 0;
  int edges = 0;
  int e0 = 0;

  always #10 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  tmr8_pwm u_tmr8_pwm (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wave_a(wave_a), .wave_b(wave_b), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    #1 reg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic start(input logic [7:0] ctrl);
    wr(3'd0, ctrl);
    e0 = edges;
  endtask

  task automatic waitn(input int n);
    while (edges - e0 < n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic int tri_pos(input int n);
    int p;
    p = n % 510;
    return (p <= 255) ? p : 510 - p;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v;
    int dv[7] = '{1, 8, 32, 64, 128, 256, 1024};
    int ctc_vals[9] = '{0, 1, 2, 3, 5, 7, 12, 40, 255};
    do_reset();

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reg%0d", a), v, 0);
    end
    chk("R1 wave_a", int'(wave_a), 0);
    chk("R1 wave_b", int'(wave_b), 0);
    chk("R1 irq", int'(irq), 0);

    // R2: prescaler ratios and stop
    for (int i = 0; i < 7; i++) begin
      wr(3'd0, 8'd0);
      wr(3'd1, 8'd0);
      start(8'((i + 1) << 2));
      waitn(dv[i] - 1);
      rd(3'd1, v); chk($sformatf("R2 sel%0d before first tick", i + 1), v, 0);
      waitn(3 * dv[i]);
      rd(3'd1, v); chk($sformatf("R2 sel%0d three ticks", i + 1), v, 3);
    end
    wr(3'd0, 8'd0);
    begin
      int c0;
      rd(3'd1, c0);
      repeat (40) @(negedge clk);
      rd(3'd1, v); chk("R2 stopped holds", v, c0);
    end

    // R3 / R6 / R9 / R11: free-running mode
    do_reset();
    wr(3'd3, 8'd5);
    wr(3'd2, 8'd200);
    wr(3'd5, 8'd1);
    start(8'h04);
    waitn(5);
    rd(3'd1, v); chk("R3 count at 5", v, 5);
    rd(3'd4, v); chk("R6 no flag before match", v, 0);
    waitn(6);
    rd(3'd4, v); chk("R6 match B flag", v, 4);
    chk("R9 wave_b toggles", int'(wave_b), 1);
    waitn(201);
    rd(3'd4, v); chk("R6 match A flag", v, 6);
    chk("R9 wave_a toggles", int'(wave_a), 1);
    waitn(255);
    rd(3'd1, v); chk("R3 count 255", v, 255);
    chk("R11 irq low before overflow", int'(irq), 0);
    waitn(256);
    rd(3'd1, v); chk("R3 wrap to 0", v, 0);
    rd(3'd4, v); chk("R3 overflow flag", v, 7);
    chk("R11 irq after overflow", int'(irq), 1);
    waitn(262);
    chk("R9 wave_b second toggle", int'(wave_b), 0);

    // R10 / R11: flag clearing and masking
    wr(3'd0, 8'd0);
    wr(3'd4, 8'd0);
    rd(3'd4, v); chk("R10 write zero no effect", v, 7);
    wr(3'd4, 8'd2);
    rd(3'd4, v); chk("R10 clear bit 1", v, 5);
    wr(3'd5, 8'd0);
    chk("R11 all masked", int'(irq), 0);
    wr(3'd5, 8'd4);
    chk("R11 mask B", int'(irq), 1);
    wr(3'd4, 8'd5);
    rd(3'd4, v); chk("R10 clear rest", v, 0);
    chk("R11 irq after clear", int'(irq), 0);

    // R4 / R7: reload mode sweep
    foreach (ctc_vals[k]) begin
      int a, n, w0;
      a = ctc_vals[k];
      n = (a == 255) ? 300 : 37;
      wr(3'd0, 8'd0);
      wr(3'd1, 8'd0);
      wr(3'd4, 8'd7);
      wr(3'd2, 8'(a));
      w0 = int'(wave_a);
      start(8'h05);
      waitn(n);
      rd(3'd1, v); chk($sformatf("R4 reload %0d count", a), v, n % (a + 1));
      rd(3'd4, v); chk($sformatf("R6 reload %0d flag A", a), (v >> 1) & 1, (n >= a + 1) ? 1 : 0);
      chk($sformatf("R9 reload %0d wave", a), int'(wave_a), w0 ^ ((n / (a + 1)) & 1));
    end

    // R5 / R7 / R8: phase-correct PWM
    do_reset();
    wr(3'd2, 8'd100);
    wr(3'd3, 8'd200);
    start(8'h06);
    waitn(100);
    rd(3'd1, v); chk("R5 rising", v, tri_pos(100));
    waitn(255);
    rd(3'd1, v); chk("R5 top", v, 255);
    waitn(256);
    rd(3'd1, v); chk("R5 turn down", v, 254);
    waitn(300);
    rd(3'd1, v); chk("R5 falling", v, tri_pos(300));
    chk("R8 wave_a cleared on up match", int'(wave_a), 0);
    chk("R8 wave_b before down match", int'(wave_b), 0);
    wr(3'd2, 8'd30);
    rd(3'd2, v); chk("R7 readback buffer", v, 30);
    waitn(320);
    chk("R8 wave_b set on down match", int'(wave_b), 1);
    waitn(450);
    chk("R7 old value still active", int'(wave_a), 1);
    waitn(510);
    rd(3'd4, v); chk("R5 no overflow at zero", v & 1, 0);
    waitn(511);
    rd(3'd1, v); chk("R5 bottom", v, 1);
    rd(3'd4, v); chk("R5 overflow at bottom", v & 1, 1);
    waitn(800);
    chk("R8 wave_a cleared next rise", int'(wave_a), 0);
    waitn(930);
    chk("R7 new value after top", int'(wave_a), 0);
    waitn(1000);
    chk("R8 set at new value", int'(wave_a), 1);
    rd(3'd1, v); chk("R5 second fall", v, tri_pos(1000));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule